// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 64-bit integer core fetches next. Each cycle it takes the current program counter, the two source register values, a three-bit condition code, one flag for each control-transfer kind (conditional branch, direct jump-and-link, register jump-and-link) and the raw immediate fields that decode has already pulled out of the instruction word. It registers three results: the next program counter, a flag that says the transfer was taken, and the return address for the destination register.

Conditional branches compare the two register values for equality, signed order or unsigned order. Direct jumps add a scaled 21-bit offset to the program counter. Register jumps add a 12-bit offset to the first register value and clear bit 0 of the sum. Every other instruction, and every branch whose condition fails, steps the program counter by four. Fetch, decode, pipeline flush and misaligned-target traps belong to other blocks.

Top module: `bnpc_unit`

## Requirements
- R1: When no control flag is set, or a branch's condition fails, next_pc_o is pc_i + 4 and taken_o is 0.
- R2: A taken branch targets pc_i plus the 12-bit field imm_b_i shifted left by one and sign-extended from 13 bits (range -4096 to +4094).
- R3: Condition codes are 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal, each comparing rs1_i against rs2_i.
- R4: Condition codes 010 and 011 never take the branch, whatever the register values.
- R5: A direct jump targets pc_i plus the 20-bit field imm_j_i shifted left by one and sign-extended from 21 bits.
- R6: A register jump targets rs1_i plus the sign-extended 12-bit field imm_i_i, with bit 0 of the sum forced to zero.
- R7: link_o is pc_i + 4 for every instruction.
- R8: taken_o is 1 for every direct or register jump and for every branch whose condition holds.
- R9: When several flags are set, the register jump wins over the direct jump, which wins over the branch.
- R10: All address sums wrap modulo 2^64.
- R11: Outputs appear one clock after the inputs are sampled; a synchronous active-low reset clears next_pc_o, taken_o and link_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 64 | Program counter of the current instruction |
| rs1_i | input | 64 | First source register value |
| rs2_i | input | 64 | Second source register value |
| cond_i | input | 3 | Branch condition code |
| is_branch_i | input | 1 | Instruction is a conditional branch |
| is_jal_i | input | 1 | Instruction is a direct jump-and-link |
| is_jalr_i | input | 1 | Instruction is a register jump-and-link |
| imm_b_i | input | 12 | Raw branch offset field, in halfword units |
| imm_j_i | input | 20 | Raw direct-jump offset field, in halfword units |
| imm_i_i | input | 12 | Raw register-jump offset field, in bytes |
| next_pc_o | output | 64 | Next program counter |
| taken_o | output | 1 | Control transfer taken |
| link_o | output | 64 | Return address for the destination register |

## Verification
On every cycle the assertions check that sequential flow steps by four, that both jump kinds always raise the taken flag, that a register-jump target is even, that reserved condition codes never take, and that a fall-through next PC always equals the link value. The exact targets of each condition under signed and unsigned operand pairs, the extreme positive and negative offsets, the wrap past the top of the address space and the priority between simultaneous flags are shown only by the bench's vectors. Reset clearing in mid-run is a directed scenario.

// File: rtl/bnpc_pkg.sv
// Package: shared widths and the branch condition encoding.
// Assumes a 64-bit address space; condition values match the field that
// decode forwards unchanged.
package bnpc_pkg;
    localparam int XLEN    = 64;
    localparam int IMMB_W  = 12;
    localparam int IMMJ_W  = 20;
    localparam int IMMI_W  = 12;
    localparam int COND_W  = 3;
    localparam int STEP    = 4;

    typedef enum logic [COND_W-1:0] {
        CMP_EQ   = 3'b000,
        CMP_NE   = 3'b001,
        CMP_RSV0 = 3'b010,
        CMP_RSV1 = 3'b011,
        CMP_LT   = 3'b100,
        CMP_GE   = 3'b101,
        CMP_LTU  = 3'b110,
        CMP_GEU  = 3'b111
    } cmp_code_e;
endpackage

// File: rtl/bnpc_sext.sv
// Module: scales a raw offset field by 2^SHIFT and sign-extends it to OUT_W.
// Assumes OUT_W > IN_W + SHIFT. Purely combinational.
module bnpc_sext #(
    parameter int IN_W  = 12,
    parameter int SHIFT = 1,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [OUT_W-1:0] ext_o
);
    localparam int FILL_W = OUT_W - IN_W - SHIFT;

    generate
        if (SHIFT == 0) begin : g_noscale
            // Plain sign extension, no scaling.
            assign ext_o = {{FILL_W{raw_i[IN_W-1]}}, raw_i};
        end else begin : g_scale
            // Sign extension with SHIFT zero bits appended.
            assign ext_o = {{FILL_W{raw_i[IN_W-1]}}, raw_i, {SHIFT{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/bnpc_cmp.sv
// Module: evaluates a branch condition on two register values.
// Assumes the code encoding of bnpc_pkg; reserved codes give false.
module bnpc_cmp
    import bnpc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [COND_W-1:0] code_i,
    output logic              hold_o
);
    logic eq, lt_s, lt_u;

    // Three basic relations shared by all conditions.
    always_comb begin
        eq   = (a_i == b_i);
        lt_s = ($signed(a_i) < $signed(b_i));
        lt_u = (a_i < b_i);
    end

    // Pick the relation named by the code and its polarity.
    always_comb begin
        unique case (cmp_code_e'(code_i))
            CMP_EQ:   hold_o = eq;
            CMP_NE:   hold_o = !eq;
            CMP_LT:   hold_o = lt_s;
            CMP_GE:   hold_o = !lt_s;
            CMP_LTU:  hold_o = lt_u;
            CMP_GEU:  hold_o = !lt_u;
            default:  hold_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bnpc_unit.sv
// Module: next-PC selector for branches and jumps, outputs registered.
// Assumes immediates arrive as raw, unscaled fields and at most one kind of
// transfer is intended; simultaneous flags resolve register jump first,
// then direct jump, then branch. Synchronous active-low reset.
module bnpc_unit
    import bnpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   rs1_i,
    input  logic [XLEN-1:0]   rs2_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              is_branch_i,
    input  logic              is_jal_i,
    input  logic              is_jalr_i,
    input  logic [IMMB_W-1:0] imm_b_i,
    input  logic [IMMJ_W-1:0] imm_j_i,
    input  logic [IMMI_W-1:0] imm_i_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic [XLEN-1:0]   link_o
);
    logic [XLEN-1:0] off_b, off_j, off_i;
    logic [XLEN-1:0] seq_pc, br_tgt, jal_tgt, jalr_sum, npc_d;
    logic            cond_ok, taken_d;

    bnpc_sext #(.IN_W(IMMB_W), .SHIFT(1), .OUT_W(XLEN)) i_sext_b (.raw_i(imm_b_i), .ext_o(off_b));
    bnpc_sext #(.IN_W(IMMJ_W), .SHIFT(1), .OUT_W(XLEN)) i_sext_j (.raw_i(imm_j_i), .ext_o(off_j));
    bnpc_sext #(.IN_W(IMMI_W), .SHIFT(0), .OUT_W(XLEN)) i_sext_i (.raw_i(imm_i_i), .ext_o(off_i));

    bnpc_cmp #(.W(XLEN)) i_cmp (.a_i(rs1_i), .b_i(rs2_i), .code_i(cond_i), .hold_o(cond_ok));

    // Candidate targets, all wrapping modulo 2^XLEN.
    always_comb begin
        seq_pc   = pc_i + XLEN'(STEP);
        br_tgt   = pc_i + off_b;
        jal_tgt  = pc_i + off_j;
        jalr_sum = rs1_i + off_i;
    end

    // Prioritised choice of next PC and taken flag.
    always_comb begin
        if (is_jalr_i) begin
            npc_d   = {jalr_sum[XLEN-1:1], 1'b0};
            taken_d = 1'b1;
        end else if (is_jal_i) begin
            npc_d   = jal_tgt;
            taken_d = 1'b1;
        end else if (is_branch_i && cond_ok) begin
            npc_d   = br_tgt;
            taken_d = 1'b1;
        end else begin
            npc_d   = seq_pc;
            taken_d = 1'b0;
        end
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o <= '0;
            taken_o   <= 1'b0;
            link_o    <= '0;
        end else begin
            next_pc_o <= npc_d;
            taken_o   <= taken_d;
            link_o    <= seq_pc;
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_branch_i && !is_jal_i && !is_jalr_i) |=> (next_pc_o == $past(pc_i) + 64'd4 && !taken_o)); // R1
    AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch_i && !is_jal_i && !is_jalr_i && cond_i[2:1] == 2'b01) |=> !taken_o); // R4
    AST_JALR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        is_jalr_i |=> !next_pc_o[0]); // R6
    AST_FALLTHRU_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> (next_pc_o == link_o)); // R7
    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jal_i || is_jalr_i) |=> taken_o); // R8
endmodule

// File: tb/test_bnpc_unit.sv
module test_bnpc_unit;
    typedef struct packed {
        logic [63:0] pc;
        logic [63:0] rs1;
        logic [63:0] rs2;
        logic [2:0]  cond;
        logic        br;
        logic        jal;
        logic        jalr;
        logic [11:0] immb;
        logic [19:0] immj;
        logic [11:0] immi;
        logic [63:0] npc;
        logic        tk;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VEC [NV] = '{
        '{64'h1000, 64'd0, 64'd0, 3'b000, 1'b0, 1'b0, 1'b0, 12'h000, 20'h0, 12'h0, 64'h1004, 1'b0, 8'd1},  // R1 plain
        '{64'h1000, 64'd5, 64'd5, 3'b000, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1010, 1'b1, 8'd3},  // R3 eq taken
        '{64'h1000, 64'd5, 64'd6, 3'b000, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1004, 1'b0, 8'd1},  // R1 eq fails
        '{64'h1000, 64'd5, 64'd6, 3'b001, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1010, 1'b1, 8'd3},  // R3 ne
        '{64'h1000, M1,    64'd1, 3'b100, 1'b1, 1'b0, 1'b0, 12'hFFE, 20'h0, 12'h0, 64'h0FFC, 1'b1, 8'd2},  // R2 neg offset, R3 lt signed
        '{64'h1000, M1,    64'd1, 3'b110, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1004, 1'b0, 8'd3},  // R3 ltu fails
        '{64'h1000, 64'd1, M1,    3'b110, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1010, 1'b1, 8'd3},  // R3 ltu holds
        '{64'h1000, 64'd1, M1,    3'b101, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1010, 1'b1, 8'd3},  // R3 ge signed
        '{64'h1000, M1,    64'd1, 3'b101, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1004, 1'b0, 8'd3},  // R3 ge signed fails
        '{64'h1000, M1,    64'd1, 3'b111, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1010, 1'b1, 8'd3},  // R3 geu
        '{64'h1000, 64'd3, 64'd3, 3'b111, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1010, 1'b1, 8'd3},  // R3 geu equal
        '{64'h1000, 64'd2, 64'd3, 3'b111, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1004, 1'b0, 8'd3},  // R3 geu fails
        '{64'h1000, 64'd5, 64'd5, 3'b010, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1004, 1'b0, 8'd4},  // R4 code 010
        '{64'h1000, 64'd5, 64'd6, 3'b011, 1'b1, 1'b0, 1'b0, 12'h008, 20'h0, 12'h0, 64'h1004, 1'b0, 8'd4},  // R4 code 011
        '{64'h1000, 64'd5, 64'd5, 3'b000, 1'b1, 1'b0, 1'b0, 12'h7FF, 20'h0, 12'h0, 64'h1FFE, 1'b1, 8'd2},  // R2 max offset
        '{64'h1000, 64'd5, 64'd5, 3'b000, 1'b1, 1'b0, 1'b0, 12'h800, 20'h0, 12'h0, 64'h0000, 1'b1, 8'd2},  // R2 min offset
        '{64'h1000, 64'd0, 64'd0, 3'b000, 1'b0, 1'b1, 1'b0, 12'h000, 20'h00010, 12'h0, 64'h1020, 1'b1, 8'd5}, // R5 fwd
        '{64'h200000, 64'd0, 64'd0, 3'b000, 1'b0, 1'b1, 1'b0, 12'h000, 20'h80000, 12'h0, 64'h100000, 1'b1, 8'd5}, // R5 min
        '{64'h1000, 64'h2001, 64'd0, 3'b000, 1'b0, 1'b0, 1'b1, 12'h000, 20'h0, 12'h004, 64'h2004, 1'b1, 8'd6}, // R6 clear bit0
        '{64'h1000, 64'h3000, 64'd0, 3'b000, 1'b0, 1'b0, 1'b1, 12'h000, 20'h0, 12'hFFF, 64'h2FFE, 1'b1, 8'd6}, // R6 neg imm
        '{64'h1000, 64'h4000, 64'd5, 3'b000, 1'b1, 1'b1, 1'b1, 12'h008, 20'h00010, 12'h000, 64'h4000, 1'b1, 8'd9}, // R9 jalr first
        '{64'h1000, 64'd5, 64'd6, 3'b000, 1'b1, 1'b1, 1'b0, 12'h008, 20'h00010, 12'h000, 64'h1020, 1'b1, 8'd9}  // R9 jal over branch
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] pc, rs1, rs2;
    logic [2:0]  cond;
    logic        br, jal, jalr;
    logic [11:0] immb, immi;
    logic [19:0] immj;
    logic [63:0] next_pc;
    logic        taken;
    logic [63:0] link;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    bnpc_unit i_bnpc_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc), .rs1_i(rs1), .rs2_i(rs2), .cond_i(cond),
        .is_branch_i(br), .is_jal_i(jal), .is_jalr_i(jalr), .imm_b_i(immb),
        .imm_j_i(immj), .imm_i_i(immi), .next_pc_o(next_pc), .taken_o(taken), .link_o(link)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        pc = v.pc; rs1 = v.rs1; rs2 = v.rs2; cond = v.cond;
        br = v.br; jal = v.jal; jalr = v.jalr;
        immb = v.immb; immj = v.immj; immi = v.immi;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pc = 64'h1234; rs1 = 64'd7; rs2 = 64'd7; cond = 3'b000;
        br = 1'b1; jal = 1'b0; jalr = 1'b0; immb = 12'h010; immj = '0; immi = '0;
        repeat (3) @(posedge clk);
        #1;
        check64("R11 reset next_pc", next_pc, 64'd0);
        check64("R11 reset taken", {63'd0, taken}, 64'd0);
        check64("R11 reset link", link, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k]);
            check64($sformatf("R%0d vec%0d next_pc", VEC[k].req, k), next_pc, VEC[k].npc);
            check64($sformatf("R8 vec%0d taken", k), {63'd0, taken}, {63'd0, VEC[k].tk});
            check64($sformatf("R7 vec%0d link", k), link, VEC[k].pc + 64'd4);
        end

        // R10: wrap at the top of the address space
        drive('{64'hFFFF_FFFF_FFFF_FFFC, 64'd0, 64'd0, 3'b000, 1'b0, 1'b0, 1'b0,
                12'h0, 20'h0, 12'h0, 64'd0, 1'b0, 8'd10});
        check64("R10 wrap next_pc", next_pc, 64'd0);
        check64("R10 wrap link", link, 64'd0);
        drive('{64'd0, M1, 64'd0, 3'b000, 1'b0, 1'b0, 1'b1,
                12'h0, 20'h0, 12'h002, 64'd0, 1'b1, 8'd10});
        check64("R10 jalr wrap", next_pc, 64'd0);

        // R11: output changes only after the capturing edge
        @(negedge clk);
        pc = 64'h5000; br = 1'b0; jal = 1'b0; jalr = 1'b0;
        #1;
        check64("R11 latency hold", next_pc, 64'd0);
        @(posedge clk);
        #1;
        check64("R11 latency update", next_pc, 64'h5004);

        // R11: reset in mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0; jal = 1'b1; immj = 20'h00100;
        @(posedge clk);
        #1;
        check64("R11 midrun next_pc", next_pc, 64'd0);
        check64("R11 midrun taken", {63'd0, taken}, 64'd0);
        check64("R11 midrun link", link, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check64("R5 after reset", next_pc, 64'h5200);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule